// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is one compare channel for an 8-bit timer. A CPU writes a compare value over a small register bus. On every enabled timer tick, an equality comparator checks the running count against that value. A real hit raises a sticky interrupt flag and moves a waveform pin. The pin is set, cleared or toggled according to a 2-bit action field.

While the channel is in one of the two PWM modes, compare writes land in a shadow buffer. The shadow is promoted to the active compare value only when the count sits at its maximum. This keeps pulse widths from being cut short by a write in mid-period. In the two non-PWM modes, writes take effect at once.

Software can also fire a forced compare, which moves the pin without touching the flag or the counter. Any write to the count suppresses the match on the next tick. A small counter is built in so the channel can run on its own. It counts up and wraps, clears on a match, or counts up and down.

The register bus has no handshake. A write is accepted in the cycle it is presented, and read data is a combinational function of the address. There is therefore no back-pressure at the block's edge.

Top module: `tmr_ocu`

## Requirements
- R1: On a tick cycle with no count write, no pending block and count equal to the active compare value, the pin takes the action in control bits [3:2]: 0 = no change, 1 = toggle, 2 = clear to 0, 3 = set to 1. Without a tick or a bus write the pin never changes.
- R2: A real match sets the flag (irq, read at address 3 bit 0). The flag stays set until a write to address 3 with bit 0 high clears it. If a set and a clear fall in the same cycle, the set wins.
- R3: In modes 0 (free run) and 1 (clear on match), selected by control bits [1:0], a write to address 2 loads the active compare value at once.
- R4: In modes 2 (up/down PWM) and 3 (up PWM), a write to address 2 loads only the shadow. The shadow is copied into the active compare value on a tick while the count equals 255.
- R5: A write to the count (address 1) loads it and discards any tick in the same cycle. The compare match on the next tick is then suppressed, even when that tick finds the count equal to the compare value.
- R6: A control write (address 0) with bit 7 high, in which the written mode is 0 or 1, moves the pin at once using the action bits of that same write. It leaves the flag and the count unchanged.
- R7: A control write with bit 7 high whose written mode is 2 or 3 leaves the pin unchanged. Bit 7 always reads back as 0.
- R8: In mode 1, a real match makes the count 0 on that tick instead of incrementing it.
- R9: In modes 0, 1 and 3 the count rises by one per tick and wraps from 255 to 0. In mode 2 it reverses at 255 and at 0. at_top is high while the count is 255 and at_bottom is high while it is 0. Without a tick or a count write the count holds.
- R10: Address 2 reads the shadow in modes 2 and 3 and the active compare value in modes 0 and 1. Address 0 reads {bit 7 = 0, action, mode}.
- R11: After reset the count, compare value, shadow, flag, pin and control register are all zero, and the count runs upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one cycle per count step |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 count, 2 compare, 3 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| oc_pin | output | 1 | Waveform output |
| irq | output | 1 | Match flag, interrupt request |
| cnt_o | output | 8 | Current count |
| at_top | output | 1 | Count is at 255 |
| at_bottom | output | 1 | Count is at 0 |

## Verification
Every register result of a write or a tick appears on the cycle after the clock edge that samples it. This covers the pin, the flag, the count, the compare value, the shadow and the blocking latch. The bench therefore drives each stimulus just after a falling edge and checks the outputs at the next falling edge. Suppression from a count write applies one full tick later, so the vector table pairs each count write with a following tick row and expects no flag there. Read data depends only on the address and current state, so it is checked within the same half-cycle after the address is set.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_CLRMATCH = 2'd1,
    MODE_PWM_UD   = 2'd2,
    MODE_PWM_UP   = 2'd3
  } ocu_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } ocu_act_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  localparam int FORCE_BIT = 7;

  function automatic logic pin_after(ocu_act_e act, logic cur);
    case (act)
      ACT_TOGGLE: pin_after = ~cur;
      ACT_CLEAR:  pin_after = 1'b0;
      ACT_SET:    pin_after = 1'b1;
      default:    pin_after = cur;
    endcase
  endfunction
endpackage

// File: rtl/ocu_counter.sv
module ocu_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         updown,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         at_top,
  output logic         at_bottom
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic rising;
  logic [W-1:0] step_val;
  logic         step_rising;

  assign at_top    = (cnt == MAXV);
  assign at_bottom = (cnt == '0);

  always_comb begin
    step_val    = cnt + ONE;
    step_rising = rising;
    if (updown) begin
      if (rising) begin
        if (at_top) begin
          step_val    = cnt - ONE;
          step_rising = 1'b0;
        end
      end else if (at_bottom) begin
        step_rising = 1'b1;
      end else begin
        step_val = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (tick) begin
      if (clr) begin
        cnt <= '0;
      end else begin
        cnt    <= step_val;
        rising <= step_rising;
      end
    end
  end
endmodule

// File: rtl/ocu_compare.sv
module ocu_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pwm,
  input  logic         cmp_we,
  input  logic         cnt_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic         at_top,
  output logic [W-1:0] ocr_q,
  output logic [W-1:0] shadow_q,
  output logic         match
);
  logic blk_q;
  logic live_tick;

  assign live_tick = tick && !cnt_we;
  assign match     = live_tick && !blk_q && (cnt == ocr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
    end else if (cnt_we) begin
      blk_q <= 1'b1;
    end else if (tick) begin
      blk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_q    <= '0;
      shadow_q <= '0;
    end else if (!pwm) begin
      if (cmp_we) begin
        ocr_q    <= wdata;
        shadow_q <= wdata;
      end
    end else begin
      if (cmp_we) shadow_q <= wdata;
      if (live_tick && at_top) ocr_q <= shadow_q;
    end
  end
endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import ocu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     match,
  input  logic     force_i,
  input  ocu_act_e force_act,
  input  ocu_act_e cur_act,
  input  logic     flag_clr,
  output logic     pin,
  output logic     flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (force_i) begin
      pin <= pin_after(force_act, pin);
    end else if (match) begin
      pin <= pin_after(cur_act, pin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (match) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         oc_pin,
  output logic         irq,
  output logic [W-1:0] cnt_o,
  output logic         at_top,
  output logic         at_bottom
);
  localparam int CTRL_USED = 4;

  ocu_mode_e mode_q;
  ocu_act_e  act_q;
  logic      ctrl_we, cnt_we, cmp_we, flag_clr;
  logic      pwm, force_go, match;
  logic [W-1:0] ocr_q, shadow_q;

  assign ctrl_we  = bus_we && (bus_addr == A_CTRL);
  assign cnt_we   = bus_we && (bus_addr == A_CNT);
  assign cmp_we   = bus_we && (bus_addr == A_CMP);
  assign flag_clr = bus_we && (bus_addr == A_FLAG) && bus_wdata[0];
  assign pwm      = mode_q[1];
  assign force_go = ctrl_we && bus_wdata[FORCE_BIT] && !bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      act_q  <= ACT_NONE;
    end else if (ctrl_we) begin
      mode_q <= ocu_mode_e'(bus_wdata[1:0]);
      act_q  <= ocu_act_e'(bus_wdata[3:2]);
    end
  end

  ocu_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ld        (cnt_we),
    .ld_val    (bus_wdata),
    .updown    (mode_q == MODE_PWM_UD),
    .clr       (match && (mode_q == MODE_CLRMATCH)),
    .cnt       (cnt_o),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  ocu_compare #(.W(W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pwm      (pwm),
    .cmp_we   (cmp_we),
    .cnt_we   (cnt_we),
    .wdata    (bus_wdata),
    .cnt      (cnt_o),
    .at_top   (at_top),
    .ocr_q    (ocr_q),
    .shadow_q (shadow_q),
    .match    (match)
  );

  ocu_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .force_i   (force_go),
    .force_act (ocu_act_e'(bus_wdata[3:2])),
    .cur_act   (act_q),
    .flag_clr  (flag_clr),
    .pin       (oc_pin),
    .flag      (irq)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(W-CTRL_USED){1'b0}}, act_q, mode_q};
      A_CNT:   bus_rdata = cnt_o;
      A_CMP:   bus_rdata = pwm ? shadow_q : ocr_q;
      default: bus_rdata = {{(W-1){1'b0}}, irq};
    endcase
  end
endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic         oc_pin,
  input logic         irq,
  input logic [W-1:0] cnt_o
);
  // R1
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_we) |=> $stable(oc_pin));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr == 2'd3 && bus_wdata[0])) |=> irq);

  // R5
  cnt_write_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && !irq) |=> !irq);

  // R5
  blocked_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_we && bus_addr == 2'd1) && !irq) |=> !irq);

  // R6
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && bus_wdata[7] && !tick && !irq) |=> (!irq && $stable(cnt_o)));

  // R7
  force_pwm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && bus_wdata[7] && bus_wdata[1] && !tick) |=> $stable(oc_pin));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !bus_we) |=> $stable(cnt_o));
endmodule

bind tmr_ocu ocu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .oc_pin    (oc_pin),
  .irq       (irq),
  .cnt_o     (cnt_o)
);

// File: tb/tmr_ocu_bench.sv
module tmr_ocu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       oc_pin, irq, at_top, at_bottom;
  logic [7:0] cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_ocu u_tmr_ocu (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_pin(oc_pin), .irq(irq),
    .cnt_o(cnt_o), .at_top(at_top), .at_bottom(at_bottom)
  );

  // {we, addr, wdata, tick, exp_cnt, exp_pin, exp_flag}
  localparam int NV = 30;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h04, 1'b0, 8'd0,   1'b0, 1'b0},
    {1'b1, 2'd2, 8'h03, 1'b0, 8'd0,   1'b0, 1'b0},
    {1'b1, 2'd1, 8'h03, 1'b0, 8'd3,   1'b0, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd4,   1'b0, 1'b0},
    {1'b1, 2'd1, 8'h02, 1'b1, 8'd2,   1'b0, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd3,   1'b0, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd4,   1'b1, 1'b1},
    {1'b1, 2'd3, 8'h01, 1'b0, 8'd4,   1'b1, 1'b0},
    {1'b1, 2'd0, 8'h88, 1'b0, 8'd4,   1'b0, 1'b0},
    {1'b1, 2'd0, 8'h8C, 1'b0, 8'd4,   1'b1, 1'b0},
    {1'b1, 2'd0, 8'h05, 1'b0, 8'd4,   1'b1, 1'b0},
    {1'b1, 2'd2, 8'h05, 1'b0, 8'd4,   1'b1, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd5,   1'b1, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd0,   1'b0, 1'b1},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd1,   1'b0, 1'b1},
    {1'b1, 2'd3, 8'h01, 1'b0, 8'd1,   1'b0, 1'b0},
    {1'b1, 2'd0, 8'h0F, 1'b0, 8'd1,   1'b0, 1'b0},
    {1'b1, 2'd2, 8'h07, 1'b0, 8'd1,   1'b0, 1'b0},
    {1'b1, 2'd1, 8'h05, 1'b0, 8'd5,   1'b0, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd6,   1'b0, 1'b0},
    {1'b1, 2'd1, 8'h04, 1'b0, 8'd4,   1'b0, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd5,   1'b0, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd6,   1'b1, 1'b1},
    {1'b1, 2'd0, 8'h8B, 1'b0, 8'd6,   1'b1, 1'b1},
    {1'b1, 2'd1, 8'hFF, 1'b0, 8'd255, 1'b1, 1'b1},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd0,   1'b1, 1'b1},
    {1'b1, 2'd3, 8'h01, 1'b0, 8'd0,   1'b1, 1'b0},
    {1'b1, 2'd1, 8'h06, 1'b0, 8'd6,   1'b1, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd7,   1'b1, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'd8,   1'b0, 1'b1}
  };

  // Requirement covered by each vector row
  localparam string TAG [NV] = '{
    "R1", "R3", "R5", "R5", "R5", "R5", "R1", "R2", "R6", "R6",
    "R8", "R3", "R8", "R8", "R2", "R2", "R4", "R4", "R5", "R5",
    "R5", "R5", "R4", "R7", "R9", "R4", "R2", "R5", "R5", "R4"
  };

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // drive one cycle (called just after a falling edge), return at next falling edge
  task automatic cycle(input logic we, input logic [1:0] a, input logic [7:0] d, input logic tk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] a, input int exp, input string req);
    bus_addr = a;
    #1;
    check(req, "rdata", bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "cnt", cnt_o, 0);
    check("R11", "pin", oc_pin, 0);
    check("R11", "flag", irq, 0);
    check("R11", "at_bottom", at_bottom, 1);
    read_chk(2'd2, 0, "R11");
    read_chk(2'd0, 0, "R11");

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][21], VEC[i][20:19], VEC[i][18:11], VEC[i][10]);
      check(TAG[i], $sformatf("vec%0d cnt", i), cnt_o, VEC[i][9:2]);
      check(TAG[i], $sformatf("vec%0d pin", i), oc_pin, VEC[i][1]);
      check(TAG[i], $sformatf("vec%0d flag", i), irq, VEC[i][0]);
    end

    // R10: shadow read in PWM, active read otherwise (active is 7 now)
    cycle(1'b1, 2'd2, 8'h09, 1'b0);
    read_chk(2'd2, 9, "R10");
    read_chk(2'd3, 1, "R2");
    // R7: force bit reads back zero, pin untouched in PWM
    cycle(1'b1, 2'd0, 8'h87, 1'b0);
    read_chk(2'd0, 8'h07, "R7");
    check("R7", "pin", oc_pin, 0);
    cycle(1'b1, 2'd0, 8'h00, 1'b0);
    read_chk(2'd2, 7, "R10");
    // R2: set wins over a clear in the same cycle
    cycle(1'b1, 2'd3, 8'h01, 1'b0);
    check("R2", "flag clr", irq, 0);
    cycle(1'b1, 2'd1, 8'd6, 1'b0);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    check("R1", "no act pin", oc_pin, 0);
    cycle(1'b1, 2'd3, 8'h01, 1'b1);
    check("R2", "set beats clr", irq, 1);

    // R9: up/down reversal at both ends
    cycle(1'b1, 2'd0, 8'h02, 1'b0);
    cycle(1'b1, 2'd1, 8'd254, 1'b0);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    check("R9", "ud cnt", cnt_o, 255);
    check("R9", "at_top", at_top, 1);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    check("R9", "ud down", cnt_o, 254);
    cycle(1'b1, 2'd1, 8'd1, 1'b0);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    check("R9", "ud bottom", cnt_o, 0);
    check("R9", "at_bottom", at_bottom, 1);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    check("R9", "ud up", cnt_o, 1);
    cycle(1'b0, 2'd0, 8'h00, 1'b0);
    check("R9", "hold", cnt_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule